// File: doc/BRIEF.md
# Countdown Event Timer Channel

A single timer channel that counts down once per enable tick (nominally a 1 MHz pulse) and raises a level-sensitive interrupt when the count runs out. Software programs it through two 32-bit registers. The control word at offset 0x0 holds three fields: a run bit, a repeat-mode bit and a 29-bit reload value. The status word at offset 0x4 shows the pending interrupt and the live count. Writing a one to the acknowledge bit at offset 0x4 drops the interrupt.

Loading a value n makes the channel expire on the (n+1)-th tick after the load. In one-shot mode the channel then halts at zero. In repeat mode it reloads n and keeps running, which gives a period of n+1 ticks. Writing an all-zero word to the control register stops the channel.

Top module: `evt_timer`

## Requirements
- R1: After reset the channel is halted, its count is 0, the interrupt is low, and both registers read as 0.
- R2: A write to offset 0x0 latches the run bit (bit 31), the repeat bit (bit 30) and the reload value (bits 28:0). It restarts the count at that value even when the channel is already running. A read at 0x0 returns these three fields, and bit 29 reads as 0.
- R3: While running, the count drops by one on each tick. A loaded value n raises the interrupt on the (n+1)-th tick. Ticks have no effect while the channel is halted.
- R4: In one-shot mode (bit 30 = 0), expiry clears the run bit and the count stays at 0. Further ticks do not raise the interrupt again.
- R5: In repeat mode (bit 30 = 1), expiry reloads the count with the stored value and the channel keeps running. The interrupt then recurs every n+1 ticks.
- R6: Writing zero to offset 0x0 stops the channel. Its count stays frozen and no new interrupt is raised.
- R7: The interrupt output stays high until a write to offset 0x4 with bit 30 set. A write to 0x4 with bit 30 clear has no effect.
- R8: When an acknowledge write and an expiry fall in the same cycle, the interrupt stays high.
- R9: A read at offset 0x4 returns the pending flag in bit 30 and the current count in bits 28:0. All other bits read as 0.
- R10: When a write to 0x0 and a tick fall in the same cycle, the write wins and the tick is not counted.
- R11: Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse, one clock wide |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 4 | Byte offset for the read and the write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, a combinational function of busAddr |
| irq | output | 1 | Level-sensitive expiry interrupt |

## Verification
The bench goes after the n+1 off-by-one first. A design that reloads n-1, or that checks for zero before decrementing, shows its interrupt one tick early or late. It then targets the collision of an acknowledge with an expiry: a design that lets the acknowledge win loses an event. It also drives a load in the same cycle as a tick; a design that counts that tick starts one below the value written. Finally it looks for a one-shot channel that fails to halt and fires again, and for a repeat channel that reloads zero instead of the stored value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic load;    // take reload value and count from the write bus
    logic dec;     // step the count down by one
    logic reload;  // copy stored reload value into the count
    logic expire;  // count ran out this cycle
    logic clrIrq;  // software acknowledge
  } tmrStrobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter logic [ADDR_W-1:0] LOAD_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cntZero,
  output tmrStrobe_t        strb,
  output logic              enOut,
  output logic              perOut
);
  logic wrLoad, wrStat, stepOk;
  logic enQ, perQ;

  assign wrLoad = busWrite && (busAddr == LOAD_OFS);
  assign wrStat = busWrite && (busAddr == STAT_OFS);
  // a load in the same cycle swallows the tick
  assign stepOk = !wrLoad && enQ && tick;

  always_comb begin
    strb        = '0;
    strb.load   = wrLoad;
    strb.dec    = stepOk && !cntZero;
    strb.expire = stepOk && cntZero;
    strb.reload = stepOk && cntZero && perQ;
    strb.clrIrq = wrStat && busWdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      perQ <= 1'b0;
    end else if (wrLoad) begin
      enQ  <= busWdata[EN_BIT];
      perQ <= busWdata[PER_BIT];
    end else if (strb.expire && !perQ) begin
      enQ <= 1'b0;
    end
  end

  assign enOut  = enQ;
  assign perOut = perQ;
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter logic [ADDR_W-1:0] LOAD_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              enIn,
  input  logic              perIn,
  output logic              cntZero,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  loadVal,
  output logic              irq,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, loadQ;
  logic irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      loadQ <= '0;
    end else if (strb.load) begin
      cntQ  <= busWdata[CNT_W-1:0];
      loadQ <= busWdata[CNT_W-1:0];
    end else if (strb.reload) begin
      cntQ <= loadQ;
    end else if (strb.dec) begin
      cntQ <= cntQ - ONE;
    end
  end

  // expiry has priority over acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            irqQ <= 1'b0;
    else if (strb.expire) irqQ <= 1'b1;
    else if (strb.clrIrq) irqQ <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == LOAD_OFS) begin
      busRdata[CNT_W-1:0] = loadQ;
      busRdata[EN_BIT]    = enIn;
      busRdata[PER_BIT]   = perIn;
    end else if (busAddr == STAT_OFS) begin
      busRdata[CNT_W-1:0] = cntQ;
      busRdata[CLR_BIT]   = irqQ;
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntVal  = cntQ;
  assign loadVal = loadQ;
  assign irq     = irqQ;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter logic [ADDR_W-1:0] LOAD_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  tmrStrobe_t strb;
  logic cntZero, enVal, perVal;
  logic [CNT_W-1:0] cntVal, loadVal;

  evt_timer_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .PER_BIT(PER_BIT),
    .CLR_BIT(CLR_BIT), .LOAD_OFS(LOAD_OFS), .STAT_OFS(STAT_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .cntZero(cntZero),
    .strb(strb), .enOut(enVal), .perOut(perVal)
  );

  evt_timer_dp #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT),
    .PER_BIT(PER_BIT), .CLR_BIT(CLR_BIT), .LOAD_OFS(LOAD_OFS), .STAT_OFS(STAT_OFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busAddr(busAddr), .enIn(enVal), .perIn(perVal), .cntZero(cntZero),
    .cntVal(cntVal), .loadVal(loadVal), .irq(irq), .busRdata(busRdata)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 29,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter logic [ADDR_W-1:0] LOAD_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irq,
  input logic              enVal,
  input logic              perVal,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  loadVal
);
  logic wrLoad, wrAck, fire;
  assign wrLoad = busWrite && (busAddr == LOAD_OFS);
  assign wrAck  = busWrite && (busAddr == STAT_OFS) && busWdata[CLR_BIT];
  assign fire   = !wrLoad && enVal && tick && (cntVal == '0);

  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrLoad |=> (cntVal == $past(busWdata[CNT_W-1:0])) && (enVal == $past(busWdata[EN_BIT]))
               && (perVal == $past(busWdata[PER_BIT])));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLoad && enVal && tick && cntVal != '0) |=> cntVal == CNT_W'($past(cntVal) - 1'b1));

  // also covers R6: a stopped channel holds its count
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLoad && !(enVal && tick)) |=> $stable(cntVal));

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !fire) |=> !irq);

  p_oneshot_halt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !perVal) |=> (!enVal && cntVal == '0));

  p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fire && perVal) |=> (enVal && cntVal == $past(loadVal)));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !wrAck) |=> irq);

  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && !fire) |=> !irq);

  p_expire_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> irq);
endmodule

bind evt_timer evt_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT),
  .PER_BIT(PER_BIT), .CLR_BIT(CLR_BIT), .LOAD_OFS(LOAD_OFS), .STAT_OFS(STAT_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .irq(irq), .enVal(enVal), .perVal(perVal),
  .cntVal(cntVal), .loadVal(loadVal)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic busWrite = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irq;

  int nChecks = 0;
  int nErrors = 0;

  // behavioural reference state
  bit mEn = 0, mPer = 0, mIrq = 0;
  int unsigned mLoad = 0, mCnt = 0;

  always #2.5 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update at each edge (inputs are stable there)
  always @(posedge clk) begin
    bit wl, ack, fire;
    if (!rstN) begin
      mEn = 0; mPer = 0; mIrq = 0; mLoad = 0; mCnt = 0;
    end else begin
      wl   = busWrite && busAddr == 4'h0;
      ack  = busWrite && busAddr == 4'h4 && busWdata[30];
      fire = !wl && mEn && tick && mCnt == 0;
      if (ack) mIrq = 0;
      if (fire) mIrq = 1;
      if (wl) begin
        mEn = busWdata[31]; mPer = busWdata[30];
        mLoad = busWdata & 32'h1FFF_FFFF; mCnt = mLoad;
      end else if (mEn && tick) begin
        if (mCnt == 0) begin
          if (mPer) mCnt = mLoad; else mEn = 0;
        end else mCnt = mCnt - 1;
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    if (a == 4'h0) return {mEn, mPer, 1'b0, mLoad[28:0]};
    if (a == 4'h4) return {1'b0, mIrq, 1'b0, mCnt[28:0]};
    return 32'h0;
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    chk(irq === mIrq, "R7 irq level vs model", {31'b0, irq}, {31'b0, mIrq});
    chk(busRdata === modelRead(busAddr), "R9 readback vs model", busRdata, modelRead(busAddr));
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit t);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d; tick = t;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0; tick = 1'b0;
  endtask

  task automatic tickN(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #2;
    chk(busRdata === exp, tag, busRdata, exp);
  endtask

  task automatic irqChk(input bit exp, input string tag);
    @(negedge clk);
    #2;
    chk(irq === exp, tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic runSeq();
    repeat (3) @(negedge clk);
    irqChk(0, "R1 irq low after reset");
    rdChk(4'h0, 32'h0, "R1 control reads zero");
    rdChk(4'h4, 32'h0, "R1 status reads zero");
    rstN = 1'b1;
    // ticks while halted
    tickN(3);
    rdChk(4'h4, 32'h0, "R3 ticks ignored while halted");

    // one-shot, n = 3
    wr(4'h0, 32'h8000_0003, 0);
    tickN(3);
    irqChk(0, "R3 no expiry after n ticks");
    tickN(1);
    irqChk(1, "R3 expiry on tick n+1");
    rdChk(4'h4, 32'h4000_0000, "R9 status pending, count 0");
    rdChk(4'h0, 32'h0000_0003, "R4 run bit cleared after one-shot");
    tickN(4);
    rdChk(4'h4, 32'h4000_0000, "R4 count holds at zero");

    // acknowledge
    wr(4'h4, 32'hBFFF_FFFF, 0);
    irqChk(1, "R7 write without bit 30 keeps irq");
    wr(4'h4, 32'h4000_0000, 0);
    irqChk(0, "R7 acknowledge drops irq");
    tickN(3);
    irqChk(0, "R4 no re-fire after one-shot");

    // periodic, n = 2
    wr(4'h0, 32'hC000_0002, 0);
    tickN(3);
    irqChk(1, "R5 first periodic expiry");
    rdChk(4'h4, 32'h4000_0002, "R5 count reloaded");
    wr(4'h4, 32'h4000_0000, 0);
    tickN(2);
    irqChk(0, "R5 not yet second period");
    tickN(1);
    irqChk(1, "R5 second expiry after n+1 ticks");
    rdChk(4'h0, 32'hC000_0002, "R2 control readback periodic");

    // stop by writing zero
    wr(4'h0, 32'h0, 0);
    rdChk(4'h4, 32'h4000_0000, "R6 stopped, count zero, irq pending");
    wr(4'h4, 32'h4000_0000, 0);
    tickN(5);
    irqChk(0, "R6 no expiry once stopped");
    rdChk(4'h4, 32'h0, "R6 count frozen");

    // load collides with tick
    wr(4'h0, 32'h8000_0005, 1);
    rdChk(4'h4, 32'h0000_0005, "R10 load wins over tick");
    tickN(2);
    rdChk(4'h4, 32'h0000_0003, "R3 count steps down");
    wr(4'h0, 32'h8000_000A, 0);
    rdChk(4'h4, 32'h0000_000A, "R2 restart while running");

    // other offset
    wr(4'h8, 32'hFFFF_FFFF, 0);
    rdChk(4'h0, 32'h8000_000A, "R11 control untouched");
    rdChk(4'h4, 32'h0000_000A, "R11 status untouched");
    rdChk(4'h8, 32'h0, "R11 unmapped reads zero");

    // acknowledge collides with expiry
    wr(4'h0, 32'hC000_0000, 0);
    tickN(1);
    irqChk(1, "R5 n=0 expires each tick");
    wr(4'h4, 32'h4000_0000, 1);
    irqChk(1, "R8 expiry beats acknowledge");
    wr(4'h4, 32'h4000_0000, 0);
    irqChk(0, "R7 acknowledge alone clears");

    // widest value, bit 29 dropped
    wr(4'h0, 32'h3FFF_FFFF, 0);
    rdChk(4'h0, 32'h1FFF_FFFF, "R2 max reload, bit 29 reads zero");
    rdChk(4'h4, 32'h1FFF_FFFF, "R9 status shows max count");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      runSeq();
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule